// File: doc/BRIEF.md
# Receive Alarm Indication Interrupt Status Controller

This block watches the level reported by an external receive alarm indication signal (AIS) detector and records every change of that level, rising or falling, in a sticky status bit. A processor reads and clears the sticky bit over a byte-wide register bus. An active-high interrupt is raised when the sticky bit is set and both enables allow it: an enable for this one alarm and an enable for the whole alarm and error group. The current detector level can also be read, live and without latching, next to the sticky bit.

The processor picks how the sticky bit is cleared, and can change the choice at run time. In reset-upon-read mode, reading the status register clears the bit. In write-to-clear mode, the processor writes a one to the bit's position. A small state machine holds the sticky bit. Its states are `ST_QUIET` (no change pending) and `ST_PENDING` (a change has been latched). Its transitions are `T_SET` (a change is seen, from either state), `T_CLEAR` (a clear request with no change in the same cycle, from `ST_PENDING` back to `ST_QUIET`) and `T_HOLD` (nothing happens and the state is kept).

The detector input passes through one register stage. The change test compares that stage with the value it held one clock earlier.

Top module: `ais_irq_ctrl`

## Requirements
- R1: While `det_en_i` is 1, a change of the registered detector level in either direction sets the change bit on the next clock edge. While `det_en_i` is 0, level changes leave the change bit untouched.
- R2: Bit 0 of address 0x0B02 reads the detector level as it was sampled at the previous clock edge. The bit has no latching, and writes do not affect it.
- R3: Bit 1 of address 0x0B02 is the change bit. Once set, it stays 1 until the selected clear mechanism removes it.
- R4: Bit 1 of address 0x0B03 is the alarm interrupt enable: 1 enables the interrupt and 0 disables it. The bit is read and written at that position.
- R5: Bit 1 of address 0x0B01 is the block enable. While it is 0, `irq_o` stays 0.
- R6: `irq_o` is 1 exactly when the change bit, the alarm enable and the block enable are all 1.
- R7: With bit 0 of address 0x0B00 at 1 (reset-upon-read), a read of 0x0B02 clears the change bit at the next edge, and writes to 0x0B02 have no effect.
- R8: With bit 0 of address 0x0B00 at 0 (write-to-clear), a write to 0x0B02 with data bit 1 at 1 clears the change bit. A write with data bit 1 at 0 leaves it set. Reads do not clear it.
- R9: When a change and a clear request fall in the same cycle, the change bit ends up set.
- R10: After reset, all enable bits, the clear-mode bit, the change bit and the registered level are 0. Unused bit positions and unmapped addresses read as 0.
- R11: `bus_rdata_o` carries the addressed register in the same cycle as `bus_rd_i`, and is 0 when no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ais_level_i | input | 1 | Alarm level from the external detector |
| det_en_i | input | 1 | Enables latching of alarm level changes |
| bus_addr_i | input | 16 | Register address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Active-high interrupt |

## Verification
The sticky bit is tried with rising and with falling alarm edges, which shows that both directions set it. It is also tried with edges while detection is disabled, which shows that the enable gates the setting. Clears are tried in both modes: reads and writes are issued against the opposite mode to confirm that only the selected mechanism clears the bit, and a write with data bit 1 at 0 confirms that no clear happens. A clear that lands in the same cycle as a new edge shows that the set wins. A long run of random toggles, strobes and enable writes then exercises every enable combination of the interrupt against the bench model.

// File: rtl/ais_irq_pkg.sv
package ais_irq_pkg;

    // Register addresses on the byte-wide bus
    localparam logic [15:0] ADR_CTRL   = 16'h0B00;
    localparam logic [15:0] ADR_BLK_EN = 16'h0B01;
    localparam logic [15:0] ADR_STATUS = 16'h0B02;
    localparam logic [15:0] ADR_ALM_EN = 16'h0B03;

    // Bit positions inside the registers
    localparam int BIT_RUR     = 0;  // control: clear-on-read select
    localparam int BIT_BLK_EN  = 1;  // block enable
    localparam int BIT_LIVE    = 0;  // status: live level
    localparam int BIT_CHANGE  = 1;  // status: sticky change
    localparam int BIT_ALM_EN  = 1;  // alarm enable

    typedef enum logic [0:0] {
        ST_QUIET   = 1'b0,
        ST_PENDING = 1'b1
    } sticky_state_e;

    typedef enum logic [1:0] {
        T_HOLD  = 2'd0,
        T_SET   = 2'd1,
        T_CLEAR = 2'd2
    } sticky_trans_e;

endpackage

// File: rtl/ais_edge_track.sv
module ais_edge_track #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic det_en_i,
    output logic level_o,
    output logic change_o
);

    logic [STAGES-1:0] stage_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= level_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[STAGES-2:0], level_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= stage_q[STAGES-1];
    end

    assign level_o  = stage_q[STAGES-1];
    assign change_o = det_en_i & (stage_q[STAGES-1] ^ prev_q);

endmodule

// File: rtl/ais_sticky_fsm.sv
module ais_sticky_fsm
    import ais_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clear_i,
    output logic pend_o
);

    sticky_state_e state_q, state_d;
    sticky_trans_e trans;

    // transition select: a set always beats a clear
    always_comb begin
        if (set_i)        trans = T_SET;
        else if (clear_i) trans = T_CLEAR;
        else              trans = T_HOLD;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (trans == T_SET) state_d = ST_PENDING;
            end
            ST_PENDING: begin
                if (trans == T_CLEAR) state_d = ST_QUIET;
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o = (state_q == ST_PENDING);
    end

endmodule

// File: rtl/ais_regfile.sv
module ais_regfile
    import ais_irq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              pend_i,
    input  logic              level_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rur_o,
    output logic              blk_en_o,
    output logic              alm_en_o,
    output logic              clear_o
);

    logic rur_q, blk_q, alm_q;
    logic hit_ctrl, hit_blk, hit_stat, hit_alm;
    logic wdata_unused;

    assign hit_ctrl = (addr_i == ADDR_W'(ADR_CTRL));
    assign hit_blk  = (addr_i == ADDR_W'(ADR_BLK_EN));
    assign hit_stat = (addr_i == ADDR_W'(ADR_STATUS));
    assign hit_alm  = (addr_i == ADDR_W'(ADR_ALM_EN));

    assign wdata_unused = ^wdata_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rur_q <= 1'b0;
            blk_q <= 1'b0;
            alm_q <= 1'b0;
        end else if (wr_i) begin
            if (hit_ctrl) rur_q <= wdata_i[BIT_RUR];
            if (hit_blk)  blk_q <= wdata_i[BIT_BLK_EN];
            if (hit_alm)  alm_q <= wdata_i[BIT_ALM_EN];
        end
    end

    // clear request for the sticky bit, mode-dependent
    always_comb begin
        if (rur_q) clear_o = rd_i & hit_stat;
        else       clear_o = wr_i & hit_stat & wdata_i[BIT_CHANGE];
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            if (hit_ctrl) rdata_o[BIT_RUR]    = rur_q;
            if (hit_blk)  rdata_o[BIT_BLK_EN] = blk_q;
            if (hit_alm)  rdata_o[BIT_ALM_EN] = alm_q;
            if (hit_stat) begin
                rdata_o[BIT_LIVE]   = level_i;
                rdata_o[BIT_CHANGE] = pend_i;
            end
        end
    end

    assign rur_o    = rur_q;
    assign blk_en_o = blk_q;
    assign alm_en_o = alm_q;

endmodule

// File: rtl/ais_irq_ctrl.sv
module ais_irq_ctrl #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ais_level_i,
    input  logic              det_en_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    logic lvl_live;
    logic chg_pulse;
    logic clr_req;
    logic pend;
    logic rur_mode;
    logic blk_en;
    logic alm_en;

    ais_edge_track #(
        .STAGES(SYNC_STAGES)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (ais_level_i),
        .det_en_i(det_en_i),
        .level_o (lvl_live),
        .change_o(chg_pulse)
    );

    ais_sticky_fsm u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (chg_pulse),
        .clear_i(clr_req),
        .pend_o (pend)
    );

    ais_regfile #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr_i),
        .rd_i    (bus_rd_i),
        .wr_i    (bus_wr_i),
        .wdata_i (bus_wdata_i),
        .pend_i  (pend),
        .level_i (lvl_live),
        .rdata_o (bus_rdata_o),
        .rur_o   (rur_mode),
        .blk_en_o(blk_en),
        .alm_en_o(alm_en),
        .clear_o (clr_req)
    );

    assign irq_o = pend & alm_en & blk_en;

endmodule

// File: rtl/ais_irq_ctrl_chk.sv
module ais_irq_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ais_level_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_rd_i,
    input logic              bus_wr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic              irq_o,
    input logic              chg_pulse,
    input logic              pend,
    input logic              rur_mode,
    input logic              blk_en,
    input logic              alm_en
);

    logic past_ok;
    logic stat_hit;
    logic clr_evt;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign stat_hit = (bus_addr_i == ADDR_W'(16'h0B02));
    assign clr_evt  = rur_mode ? (bus_rd_i & stat_hit)
                               : (bus_wr_i & stat_hit & bus_wdata_i[1]);

    a_r1_set_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pulse |=> pend);

    a_r2_live_level: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && bus_rd_i && stat_hit) |-> (bus_rdata_o[0] == $past(ais_level_i)));

    a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr_evt) |=> pend);

    a_r5_block_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_en |-> !irq_o);

    a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend && alm_en));

    a_r7_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rur_mode && bus_rd_i && stat_hit && !chg_pulse) |=> !pend);

    a_r8_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!rur_mode && bus_wr_i && stat_hit && bus_wdata_i[1] && !chg_pulse) |=> !pend);

    a_r11_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |-> (bus_rdata_o == '0));

endmodule

bind ais_irq_ctrl ais_irq_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ais_level_i(ais_level_i),
    .bus_addr_i (bus_addr_i),
    .bus_rd_i   (bus_rd_i),
    .bus_wr_i   (bus_wr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .irq_o      (irq_o),
    .chg_pulse  (chg_pulse),
    .pend       (pend),
    .rur_mode   (rur_mode),
    .blk_en     (blk_en),
    .alm_en     (alm_en)
);

// File: tb/ais_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ais_irq_ctrl_bench;

    localparam logic [15:0] A_CTRL = 16'h0B00;
    localparam logic [15:0] A_BLK  = 16'h0B01;
    localparam logic [15:0] A_STAT = 16'h0B02;
    localparam logic [15:0] A_ALM  = 16'h0B03;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ais = 1'b0;
    logic        det = 1'b0;
    logic [15:0] addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  wd = '0;
    logic [7:0]  rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench model
    logic m_q, m_d, m_pend, m_rur, m_blk, m_alm;

    always #5 clk = ~clk;

    ais_irq_ctrl u_ais_irq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ais_level_i(ais),
        .det_en_i   (det),
        .bus_addr_i (addr),
        .bus_rd_i   (rd),
        .bus_wr_i   (wr),
        .bus_wdata_i(wd),
        .bus_rdata_o(rdata),
        .irq_o      (irq)
    );

    function automatic logic [7:0] exp_rdata(input logic [15:0] a, input logic r);
        logic [7:0] v;
        v = 8'h00;
        if (r) begin
            case (a)
                A_CTRL: v[0] = m_rur;
                A_BLK:  v[1] = m_blk;
                A_ALM:  v[1] = m_alm;
                A_STAT: begin v[0] = m_q; v[1] = m_pend; end
                default: v = 8'h00;
            endcase
        end
        return v;
    endfunction

    function automatic logic exp_irq();
        return m_pend & m_alm & m_blk;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic a, input logic d, input logic [15:0] ad,
                       input logic r, input logic w, input logic [7:0] wdat,
                       input string tag);
        logic chg, clr;
        @(negedge clk);
        ais = a; det = d; addr = ad; rd = r; wr = w; wd = wdat;
        #1;
        check(rdata, exp_rdata(ad, r), tag);
        @(posedge clk);
        chg = d & (m_q ^ m_d);
        clr = m_rur ? (r && ad == A_STAT) : (w && ad == A_STAT && wdat[1]);
        if (chg)      m_pend = 1'b1;
        else if (clr) m_pend = 1'b0;
        if (w) begin
            if (ad == A_CTRL) m_rur = wdat[0];
            if (ad == A_BLK)  m_blk = wdat[1];
            if (ad == A_ALM)  m_alm = wdat[1];
        end
        m_d = m_q;
        m_q = a;
        #1;
        check({7'b0, irq}, {7'b0, exp_irq()}, "R6 irq");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
    end

    initial begin
        m_q = 0; m_d = 0; m_pend = 0; m_rur = 0; m_blk = 0; m_alm = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        cyc(0, 0, A_STAT, 1, 0, 8'h00, "R10 status");
        cyc(0, 0, A_CTRL, 1, 0, 8'h00, "R10 ctrl");
        cyc(0, 0, A_BLK,  1, 0, 8'h00, "R10 blk");
        cyc(0, 0, A_ALM,  1, 0, 8'h00, "R10 alm");
        cyc(0, 0, 16'h0B04, 1, 0, 8'h00, "R10 unmapped");
        cyc(0, 0, A_STAT, 0, 0, 8'h00, "R11 no strobe");

        // R1 edge while detection disabled
        cyc(1, 0, A_STAT, 0, 0, 8'h00, "R1");
        cyc(1, 0, A_STAT, 1, 0, 8'h00, "R1 det off");
        cyc(1, 0, A_STAT, 1, 0, 8'h00, "R2 live");
        // enables on, writes with extra bits
        cyc(1, 1, A_ALM, 0, 1, 8'hFF, "R4");
        cyc(1, 1, A_ALM, 1, 0, 8'h00, "R4 read");
        cyc(1, 1, A_BLK, 0, 1, 8'hFD, "R5 off");
        cyc(1, 1, A_BLK, 1, 0, 8'h00, "R5 read");
        // falling edge with detection on, block disabled
        cyc(0, 1, A_STAT, 0, 0, 8'h00, "R1 fall");
        cyc(0, 1, A_STAT, 1, 0, 8'h00, "R1 fall set");
        cyc(0, 1, A_STAT, 1, 0, 8'h00, "R5 gated");
        cyc(0, 1, A_BLK, 0, 1, 8'h02, "R6 enable");
        cyc(0, 1, A_STAT, 1, 0, 8'h00, "R3 sticky");
        // write-to-clear: write 0 keeps, read keeps, write 1 clears
        cyc(0, 1, A_STAT, 0, 1, 8'hFD, "R8 wr0");
        cyc(0, 1, A_STAT, 1, 0, 8'h00, "R8 kept");
        cyc(0, 1, A_STAT, 1, 0, 8'h00, "R8 read no clear");
        cyc(0, 1, A_STAT, 0, 1, 8'h02, "R8 wr1");
        cyc(0, 1, A_STAT, 1, 0, 8'h00, "R8 cleared");
        // rising edge, then reset-upon-read mode
        cyc(1, 1, A_CTRL, 0, 1, 8'h01, "R7 mode");
        cyc(1, 1, A_STAT, 0, 1, 8'h03, "R7 write ignored");
        cyc(1, 1, A_STAT, 1, 0, 8'h00, "R7 read");
        cyc(1, 1, A_STAT, 1, 0, 8'h00, "R7 cleared");
        // R9 read clear in same cycle as a change
        cyc(0, 1, A_STAT, 0, 0, 8'h00, "R9");
        cyc(0, 1, A_STAT, 1, 0, 8'h00, "R9 set wins");
        cyc(0, 1, A_STAT, 1, 0, 8'h00, "R9 after");
        cyc(0, 1, A_STAT, 1, 0, 8'h00, "R7 empty");

        // constrained random
        void'($urandom(32'h5EED_A15));
        for (int i = 0; i < 4000; i++) begin
            logic        ra, rdet, rr, rw;
            logic [15:0] radr;
            logic [7:0]  rwd;
            int          pick;
            ra   = (($urandom % 8) == 0) ? ~m_q : m_q;
            rdet = (($urandom % 4) != 0);
            pick = $urandom % 6;
            case (pick)
                0: radr = A_CTRL;
                1: radr = A_BLK;
                2, 3: radr = A_STAT;
                4: radr = A_ALM;
                default: radr = 16'($urandom);
            endcase
            rr  = (($urandom % 3) == 0);
            rw  = (($urandom % 4) == 0);
            rwd = 8'($urandom);
            cyc(ra, rdet, radr, rr, rw, rwd, "R3/R2/R11 random");
        end

        summary();
    end

endmodule